// File: doc/BRIEF.md
# Ping-Pong Frame Buffer Controller

This block joins a producing stage to a consuming stage through two memory banks of equal size. At any moment one bank belongs to the producer, which writes a frame into it, and the other belongs to the consumer, which reads the previous frame out of it. Both sides work at the same time. Between the stages there is only this pair of banks, never a deeper queue, so a frame reaches the consumer after at most one frame of delay.

A frame is a run of words. It ends when the producer flags its final word, or when the bank is full. Frames shorter than a bank are allowed, and their length is recorded for the consumer. The banks trade roles only when the producer's bank holds a finished frame and the consumer's bank has been read out completely. Whichever side finishes first stalls until the other catches up: the producer sees its ready signal drop, and the consumer sees its read-available signal drop. After reset both banks are empty and the producer owns bank 0.

Top module: `pp_frame_buffer`

## Requirements
- R1: During and right after reset, wr_ready is 1, rd_avail is 0, rd_valid is 0, wr_bank_sel is 0 and rd_bank_sel is 1.
- R2: rd_bank_sel is always the inverse of wr_bank_sel, and both change only at a role swap.
- R3: A word is accepted on a rising edge where wr_valid and wr_ready are both 1. Accepted words of a frame are stored in acceptance order.
- R4: A frame ends with the accepted word that has wr_last set, or with the DEPTH-th accepted word if wr_last never came. From the next cycle wr_ready is 0 until the following swap.
- R5: A swap happens on the first rising edge where the producer's bank holds a finished frame and the consumer's bank is drained. In the cycle after that edge, wr_ready and rd_avail are both 1.
- R6: A read is accepted on a rising edge where rd_req and rd_avail are both 1. Its word appears on rd_data with rd_valid set 1+OUT_REG cycles later (1 cycle by default).
- R7: rd_last is 1 exactly with the final word of each frame, so the consumer receives the frame length the producer wrote, including frames shorter than DEPTH.
- R8: Once the final word of a frame has been accepted for reading, rd_avail is 0 until the next swap.
- R9: wr_valid while wr_ready is 0 has no effect: no word is stored and no frame is started or lengthened.
- R10: rd_req while rd_avail is 0 has no effect: rd_valid stays 0.
- R11: Under any stall pattern on either side, every frame is delivered whole and in order, with no word lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Producer offers a word |
| wr_data | input | DATA_W | Producer word |
| wr_last | input | 1 | Offered word ends the frame |
| wr_ready | output | 1 | Producer bank can accept a word |
| wr_bank_sel | output | 1 | Bank currently owned by the producer |
| rd_req | input | 1 | Consumer asks for the next word |
| rd_avail | output | 1 | Consumer bank still holds unread words |
| rd_valid | output | 1 | rd_data carries a word |
| rd_data | output | DATA_W | Word read from the consumer bank |
| rd_last | output | 1 | rd_data is the final word of its frame |
| rd_bank_sel | output | 1 | Bank currently owned by the consumer |

## Verification
The assertions assume that the inputs are known after reset and that both sides obey the handshake only through wr_ready and rd_avail. They do not assume that wr_valid, wr_data, wr_last or rd_req are held while stalled. This is why the stall-side checks are written as implications on the block's own outputs. The bench drives inputs on falling edges. It offers words with random-looking idle gaps on both sides, and it also drives wr_valid and rd_req on purpose while the block is stalling. In every case it judges the outcome only from the ready, available and read-data ports.

// File: rtl/pp_pkg.sv
package pp_pkg;

   typedef enum logic {
      BANK_A = 1'b0,
      BANK_B = 1'b1
   } bank_e;

   typedef struct packed {
      logic vld;
      logic last;
      logic bank;
   } rd_stage_t;

   function automatic bank_e other_bank(input bank_e b);
      return (b == BANK_A) ? BANK_B : BANK_A;
   endfunction

endpackage

// File: rtl/pp_bank_slot.sv
module pp_bank_slot #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 16,
   parameter int AW     = 4,
   parameter int LW     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              fill_done,
   input  logic [LW-1:0]     fill_len,
   input  logic              rd_en,
   input  logic [AW-1:0]     raddr,
   input  logic              drain_done,
   output logic [DATA_W-1:0] rdata,
   output logic              full,
   output logic [LW-1:0]     len
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic              full_q;
   logic [LW-1:0]     len_q;

   // storage: write port from the producer, registered read port to the consumer
   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[waddr] <= wdata;
      end
      if (rd_en) begin
         rdata <= mem[raddr];
      end
   end

   // bank state: set when a frame completes here, cleared when it is read out
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         len_q  <= '0;
      end else if (fill_done) begin
         full_q <= 1'b1;
         len_q  <= fill_len;
      end else if (drain_done) begin
         full_q <= 1'b0;
      end
   end

   assign full = full_q;
   assign len  = len_q;

endmodule

// File: rtl/pp_wr_ctrl.sv
module pp_wr_ctrl #(
   parameter int DEPTH = 16,
   parameter int AW    = 4,
   parameter int LW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fire,
   input  logic          last_in,
   output logic [AW-1:0] waddr,
   output logic          frame_done,
   output logic [LW-1:0] frame_len
);

   localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);

   logic [AW-1:0] addr_q;
   logic          at_top;

   assign at_top     = (addr_q == TOP_ADDR);
   assign frame_done = fire && (last_in || at_top);
   assign frame_len  = LW'(addr_q) + LW'(1);
   assign waddr      = addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (fire) begin
         if (frame_done) begin
            addr_q <= '0;
         end else begin
            addr_q <= addr_q + AW'(1);
         end
      end
   end

endmodule

// File: rtl/pp_rd_ctrl.sv
module pp_rd_ctrl
   import pp_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int AW      = 4,
   parameter int LW      = 5,
   parameter int OUT_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic              bank,
   input  logic [LW-1:0]     frame_len,
   input  logic [DATA_W-1:0] rdata_a,
   input  logic [DATA_W-1:0] rdata_b,
   output logic [AW-1:0]     raddr,
   output logic              drain_done,
   output logic              out_valid,
   output logic              out_last,
   output logic [DATA_W-1:0] out_data
);

   logic [AW-1:0]     addr_q;
   logic              at_end;
   rd_stage_t         s1_q;
   logic [DATA_W-1:0] s1_data;

   assign at_end     = ((LW'(addr_q) + LW'(1)) == frame_len);
   assign drain_done = fire && at_end;
   assign raddr      = addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (fire) begin
         if (at_end) begin
            addr_q <= '0;
         end else begin
            addr_q <= addr_q + AW'(1);
         end
      end
   end

   // stage aligned with the registered bank read
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_q <= '0;
      end else begin
         s1_q.vld  <= fire;
         s1_q.last <= drain_done;
         s1_q.bank <= bank;
      end
   end

   assign s1_data = s1_q.bank ? rdata_b : rdata_a;

   generate
      if (OUT_REG != 0) begin : g_out_reg
         rd_stage_t         s2_q;
         logic [DATA_W-1:0] s2_data;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               s2_q    <= '0;
               s2_data <= '0;
            end else begin
               s2_q    <= s1_q;
               s2_data <= s1_data;
            end
         end
         assign out_valid = s2_q.vld;
         assign out_last  = s2_q.last;
         assign out_data  = s2_data;
      end else begin : g_out_direct
         assign out_valid = s1_q.vld;
         assign out_last  = s1_q.last;
         assign out_data  = s1_data;
      end
   endgenerate

endmodule

// File: rtl/pp_frame_buffer.sv
module pp_frame_buffer
   import pp_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int DEPTH   = 16,
   parameter int OUT_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_last,
   output logic              wr_ready,
   output logic              wr_bank_sel,
   input  logic              rd_req,
   output logic              rd_avail,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_last,
   output logic              rd_bank_sel
);

   localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LW     = $clog2(DEPTH + 1);
   localparam int NBANKS = 2;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("pp_frame_buffer: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("pp_frame_buffer: DATA_W must be at least 1");
      end
      if (OUT_REG != 0 && OUT_REG != 1) begin : g_bad_outreg
         $error("pp_frame_buffer: OUT_REG must be 0 or 1");
      end
   endgenerate

   bank_e             wr_sel_q;
   bank_e             rd_sel;
   logic              wr_fire;
   logic              rd_fire;
   logic              swap;
   logic [AW-1:0]     waddr;
   logic [AW-1:0]     raddr;
   logic              fill_done;
   logic [LW-1:0]     fill_len;
   logic              drain_done;
   logic              full_w  [NBANKS];
   logic [LW-1:0]     len_w   [NBANKS];
   logic [DATA_W-1:0] rdata_w [NBANKS];

   assign rd_sel   = other_bank(wr_sel_q);
   assign wr_ready = !full_w[wr_sel_q];
   assign rd_avail = full_w[rd_sel];
   assign wr_fire  = wr_valid && wr_ready;
   assign rd_fire  = rd_req && rd_avail;
   assign swap     = full_w[wr_sel_q] && !full_w[rd_sel];

   // role exchange: only once the producer bank is full and the consumer bank drained
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_sel_q <= BANK_A;
      end else if (swap) begin
         wr_sel_q <= other_bank(wr_sel_q);
      end
   end

   assign wr_bank_sel = wr_sel_q;
   assign rd_bank_sel = rd_sel;

   pp_wr_ctrl #(
      .DEPTH (DEPTH),
      .AW    (AW),
      .LW    (LW)
   ) u_wr (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (wr_fire),
      .last_in    (wr_last),
      .waddr      (waddr),
      .frame_done (fill_done),
      .frame_len  (fill_len)
   );

   generate
      for (genvar b = 0; b < NBANKS; b++) begin : g_bank
         localparam bank_e ME = bank_e'(b);
         pp_bank_slot #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH),
            .AW     (AW),
            .LW     (LW)
         ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (wr_fire && (wr_sel_q == ME)),
            .waddr      (waddr),
            .wdata      (wr_data),
            .fill_done  (fill_done && (wr_sel_q == ME)),
            .fill_len   (fill_len),
            .rd_en      (rd_fire && (rd_sel == ME)),
            .raddr      (raddr),
            .drain_done (drain_done && (rd_sel == ME)),
            .rdata      (rdata_w[b]),
            .full       (full_w[b]),
            .len        (len_w[b])
         );
      end
   endgenerate

   pp_rd_ctrl #(
      .DATA_W  (DATA_W),
      .AW      (AW),
      .LW      (LW),
      .OUT_REG (OUT_REG)
   ) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (rd_fire),
      .bank       (rd_sel),
      .frame_len  (len_w[rd_sel]),
      .rdata_a    (rdata_w[0]),
      .rdata_b    (rdata_w[1]),
      .raddr      (raddr),
      .drain_done (drain_done),
      .out_valid  (rd_valid),
      .out_last   (rd_last),
      .out_data   (rd_data)
   );

endmodule

// File: rtl/pp_frame_buffer_chk.sv
module pp_frame_buffer_chk #(
   parameter int OUT_REG = 0
) (
   input logic clk,
   input logic rst_n,
   input logic wr_valid,
   input logic wr_last,
   input logic wr_ready,
   input logic wr_bank_sel,
   input logic rd_req,
   input logic rd_avail,
   input logic rd_valid,
   input logic rd_last,
   input logic rd_bank_sel
);

   a_r2_sel_opposite: assert property (@(posedge clk) disable iff (!rst_n)
      wr_bank_sel != rd_bank_sel);

   a_r4_stall_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready && wr_last) |=> !wr_ready);

   a_r5_swap_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_bank_sel != $past(wr_bank_sel)) |-> $past(!wr_ready && !rd_avail));

   a_r5_ready_after_swap: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_bank_sel != $past(wr_bank_sel)) |-> (wr_ready && rd_avail));

   a_r7_last_in_word: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |-> rd_valid);

   generate
      if (OUT_REG == 0) begin : g_lat1
         a_r6_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
            rd_valid |-> $past(rd_req && rd_avail));
         a_r8_drained_unavail: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_valid && rd_last) |-> !rd_avail);
         a_r10_no_read_unavail: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_req && !rd_avail) |=> !rd_valid);
      end else begin : g_lat2
         a_r6_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
            rd_valid |-> $past(rd_req && rd_avail, 2));
      end
   endgenerate

endmodule

bind pp_frame_buffer pp_frame_buffer_chk #(.OUT_REG(OUT_REG)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_valid    (wr_valid),
   .wr_last     (wr_last),
   .wr_ready    (wr_ready),
   .wr_bank_sel (wr_bank_sel),
   .rd_req      (rd_req),
   .rd_avail    (rd_avail),
   .rd_valid    (rd_valid),
   .rd_last     (rd_last),
   .rd_bank_sel (rd_bank_sel)
);

// File: tb/tb_pp_frame_buffer.sv
module tb_pp_frame_buffer;

   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 16;
   localparam int DEPTH      = 8;
   localparam int NV         = 8;

   // [20:17] frame length, [16] producer marks final word,
   // [15:8] producer idle-before-word mask, [7:0] consumer idle-before-word mask
   localparam logic [20:0] VEC [NV] = '{
      {4'd4, 1'b1, 8'h00, 8'h00},
      {4'd1, 1'b1, 8'h00, 8'h01},
      {4'd8, 1'b0, 8'h24, 8'h81},
      {4'd8, 1'b1, 8'h00, 8'hFF},
      {4'd5, 1'b1, 8'h1F, 8'h00},
      {4'd2, 1'b1, 8'h02, 8'h02},
      {4'd7, 1'b1, 8'h55, 8'hAA},
      {4'd3, 1'b1, 8'h00, 8'h04}
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic              wr_valid;
   logic [DATA_W-1:0] wr_data;
   logic              wr_last;
   logic              wr_ready;
   logic              wr_bank_sel;
   logic              rd_req;
   logic              rd_avail;
   logic              rd_valid;
   logic [DATA_W-1:0] rd_data;
   logic              rd_last;
   logic              rd_bank_sel;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pp_frame_buffer #(
      .DATA_W  (DATA_W),
      .DEPTH   (DEPTH),
      .OUT_REG (0)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_valid    (wr_valid),
      .wr_data     (wr_data),
      .wr_last     (wr_last),
      .wr_ready    (wr_ready),
      .wr_bank_sel (wr_bank_sel),
      .rd_req      (rd_req),
      .rd_avail    (rd_avail),
      .rd_valid    (rd_valid),
      .rd_data     (rd_data),
      .rd_last     (rd_last),
      .rd_bank_sel (rd_bank_sel)
   );

   function automatic logic [DATA_W-1:0] word_of(input int k, input int i);
      return DATA_W'(k * 256 + i);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic write_word(input int k, input int i, input bit last);
      wr_valid = 1'b1;
      wr_data  = word_of(k, i);
      wr_last  = last;
      while (!wr_ready) @(negedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
      wr_last  = 1'b0;
   endtask

   task automatic read_word(input int k, input int i, input int len);
      rd_req = 1'b1;
      while (!rd_avail) @(negedge clk);
      @(negedge clk);
      rd_req = 1'b0;
      chk(rd_valid == 1'b1, "R6 rd_valid", 32'(rd_valid), 32'd1);
      chk(rd_data == word_of(k, i), "R11 word order", 32'(rd_data), 32'(word_of(k, i)));
      chk(rd_last == (i == len - 1), "R7 rd_last", 32'(rd_last), 32'(i == len - 1));
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic sel_before;
      rst_n    = 1'b0;
      wr_valid = 1'b0;
      wr_data  = '0;
      wr_last  = 1'b0;
      rd_req   = 1'b0;
      repeat (3) @(negedge clk);
      chk(rd_valid == 1'b0 && rd_avail == 1'b0, "R1 in reset", {rd_valid, rd_avail}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(wr_ready == 1'b1, "R1 wr_ready", 32'(wr_ready), 32'd1);
      chk(rd_avail == 1'b0, "R1 rd_avail", 32'(rd_avail), 32'd0);
      chk(wr_bank_sel == 1'b0 && rd_bank_sel == 1'b1, "R1 selects",
          {wr_bank_sel, rd_bank_sel}, 32'b01);

      // R10: requests before any frame exists are ignored
      rd_req = 1'b1;
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         chk(rd_valid == 1'b0, "R10 no data", 32'(rd_valid), 32'd0);
      end
      rd_req = 1'b0;

      // table walk: producer and consumer run concurrently (R3, R4, R11)
      fork
         begin
            for (int k = 0; k < NV; k++) begin
               for (int i = 0; i < int'(VEC[k][20:17]); i++) begin
                  if (VEC[k][8 + i]) begin
                     wr_valid = 1'b0;
                     @(negedge clk);
                  end
                  write_word(k, i, VEC[k][16] && (i == int'(VEC[k][20:17]) - 1));
               end
            end
         end
         begin
            for (int k = 0; k < NV; k++) begin
               for (int i = 0; i < int'(VEC[k][20:17]); i++) begin
                  if (VEC[k][i]) begin
                     rd_req = 1'b0;
                     @(negedge clk);
                  end
                  read_word(k, i, int'(VEC[k][20:17]));
               end
            end
         end
      join
      repeat (2) @(negedge clk);
      chk(rd_avail == 1'b0, "R11 nothing extra", 32'(rd_avail), 32'd0);

      // directed: producer fills a frame while the consumer still holds one
      for (int i = 0; i < 3; i++) write_word(8, i, i == 2);
      @(negedge clk);
      chk(rd_avail == 1'b1 && wr_ready == 1'b1, "R5 first swap", {rd_avail, wr_ready}, 32'b11);
      for (int i = 0; i < 2; i++) write_word(9, i, i == 1);
      chk(wr_ready == 1'b0, "R4 stall after end", 32'(wr_ready), 32'd0);
      wr_valid = 1'b1;
      wr_data  = 16'hBEEF;
      wr_last  = 1'b1;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         chk(wr_ready == 1'b0, "R9 still stalled", 32'(wr_ready), 32'd0);
      end
      wr_valid = 1'b0;
      wr_last  = 1'b0;
      sel_before = wr_bank_sel;
      for (int i = 0; i < 3; i++) read_word(8, i, 3);
      chk(rd_avail == 1'b0, "R8 drained", 32'(rd_avail), 32'd0);
      @(negedge clk);
      chk(rd_avail == 1'b1 && wr_ready == 1'b1, "R5 swap", {rd_avail, wr_ready}, 32'b11);
      chk(wr_bank_sel != sel_before && rd_bank_sel == ~wr_bank_sel, "R2 selects",
          {wr_bank_sel, rd_bank_sel}, {31'd0, ~sel_before});
      for (int i = 0; i < 2; i++) read_word(9, i, 2);
      @(negedge clk);
      chk(rd_avail == 1'b0, "R9 junk not stored", 32'(rd_avail), 32'd0);

      summary();
      $finish;
   end

endmodule